// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder/Decoder

This block joins a UART-style NRZ serial line to a serial infrared transceiver. On the transmit side it watches the NRZ line. It replaces every low bit with one narrow high pulse on the infrared output. A high bit produces no pulse at all. On the receive side it takes the short active-low pulses from the transceiver and widens each one into a low level exactly one bit period long, which rebuilds the NRZ waveform for the UART.

All timing comes from a single 3.6864 MHz clock. A 4-bit rate code selects one of thirteen bit rates, from 115.2 kbit/s down to 1.2 kbit/s, and a mode input selects the transmit pulse width. Doubling the clock doubles every rate. Two active-low indicator outputs show transmit and receive activity and can drive lamps.

Top module: `irsir_codec`

## Requirements
- R1: After reset the infrared output is low, the NRZ receive output is high, both indicators are high, and the active rate is code 6 (384 clock cycles per bit).
- R2: Rate codes 0 to 12 select 115.2k, 57.6k, 38.4k, 19.2k, 14.4k, 12.8k, 9.6k, 7.2k, 4.8k, 3.6k, 2.4k, 1.8k and 1.2k bit/s. The bit period in clock cycles is 32 × (115200 / rate), for example 32 for code 0, 192 for code 3 and 3072 for code 12.
- R3: Each low bit on the NRZ transmit input, the start bit included, gives exactly one high pulse on the infrared output, and high bits give none. Consecutive low bits give one pulse per bit period. The first pulse rises on the third rising clock edge after the input goes low.
- R4: With short_pulse_i = 1 every transmit pulse lasts 6 clock cycles (1.627 µs), whatever the rate.
- R5: With short_pulse_i = 0 every transmit pulse lasts 3/16 of the current bit period, that is 6 × (115200 / rate) cycles.
- R6: A falling edge on the active-low infrared receive input drives the NRZ receive output low. The output goes low on the third rising clock edge after the input falls and stays low for exactly one bit period.
- R7: The length of the stretched low does not depend on the received pulse width. A 6-cycle pulse and one longer than a bit period both give exactly one bit period.
- R8: A new received falling edge during a stretch restarts the bit timer, so the output stays low until one bit period after the newer edge.
- R9: Rate codes 13 to 15 are ignored and the previously active rate stays in force. After reset with such a code applied, the default rate of R1 applies.
- R10: The transmit indicator is low from the first pulse of a run of low bits until the synchronised input returns high, for one bit period per low bit, and it is low whenever the infrared output is high. The receive indicator is low exactly while the NRZ receive output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.6864 MHz timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_code_i | input | 4 | Bit rate select code, 0 to 12 valid |
| short_pulse_i | input | 1 | 1: fixed 6-cycle pulse, 0: 3/16 bit pulse |
| txd_i | input | 1 | NRZ transmit data from the UART |
| ir_tx_o | output | 1 | Pulse output to the transceiver, active high |
| ir_rx_ni | input | 1 | Pulse input from the transceiver, active low |
| rxd_o | output | 1 | Rebuilt NRZ receive data to the UART |
| tx_act_no | output | 1 | Transmit activity indicator, active low |
| rx_act_no | output | 1 | Receive activity indicator, active low |

## Verification
The bench sends whole UART frames with runs of adjacent low bits. A transmitter that does not refire at the bit boundary would lose pulses, and one that does not resynchronise on each edge would drift or add a pulse after the stop bit. The pulse length is measured in both modes at the fastest and slower rates, which catches a 3/16 width that is not scaled or a short width that is. On receive, the bench times the stretch for a minimal pulse, for a pulse longer than one bit and for a retrigger inside the stretch. A decoder that follows the input level, or that ignores the second edge, gives the wrong low length. Invalid rate codes are applied both straight after reset and after a valid code, and a design that takes them on shows a wrong bit period.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam logic [3:0]  LAST_CODE    = 4'd12;
  localparam logic [3:0]  DEFAULT_CODE = 4'd6;
  localparam int unsigned MAX_MULT     = 96;

  // bit period multiple of the fastest rate
  function automatic int unsigned rate_mult(input logic [3:0] code);
    case (code)
      4'd0:    return 1;
      4'd1:    return 2;
      4'd2:    return 3;
      4'd3:    return 6;
      4'd4:    return 8;
      4'd5:    return 9;
      4'd6:    return 12;
      4'd7:    return 16;
      4'd8:    return 24;
      4'd9:    return 32;
      4'd10:   return 48;
      4'd11:   return 64;
      4'd12:   return 96;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/irsir_sync2.sv
module irsir_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irsir_rate_sel.sv
module irsir_rate_sel
  import irsir_pkg::*;
#(
  parameter int unsigned BASE_BIT_CLKS = 32,
  parameter int unsigned CNT_W         = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       code_i,
  output logic [3:0]       code_o,
  output logic [CNT_W-1:0] bit_len_o,
  output logic [CNT_W-1:0] tri_len_o
);
  localparam int unsigned TRI_BASE = BASE_BIT_CLKS * 3 / 16;

  logic [3:0] code_q;

  // out-of-range codes leave the active rate untouched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  code_q <= DEFAULT_CODE;
    else if (code_i <= LAST_CODE) code_q <= code_i;
  end

  assign code_o    = code_q;
  assign bit_len_o = CNT_W'(BASE_BIT_CLKS * rate_mult(code_q));
  assign tri_len_o = CNT_W'(TRI_BASE * rate_mult(code_q));
endmodule

// File: rtl/irsir_tx_shaper.sv
module irsir_tx_shaper #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SHORT_CLKS  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nrz_i,
  input  logic             short_i,
  input  logic [CNT_W-1:0] bit_len_i,
  input  logic [CNT_W-1:0] tri_len_i,
  output logic             ir_o,
  output logic             busy_o
);
  logic             last_q, busy_q, pulse_q;
  logic [CNT_W-1:0] bit_cnt_q, pul_cnt_q, pul_len;
  logic             fall, wrap, start;

  assign fall    = last_q & ~nrz_i;
  assign wrap    = busy_q & ~nrz_i & (bit_cnt_q == bit_len_i - CNT_W'(1));
  assign start   = fall | wrap;
  assign pul_len = short_i ? CNT_W'(SHORT_CLKS) : tri_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= 1'b1;
      busy_q    <= 1'b0;
      bit_cnt_q <= '0;
    end else begin
      last_q <= nrz_i;
      if (fall)       busy_q <= 1'b1;
      else if (nrz_i) busy_q <= 1'b0;
      // bit timer restarts on every edge so drift never accumulates
      if (nrz_i || start) bit_cnt_q <= '0;
      else                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q   <= 1'b0;
      pul_cnt_q <= '0;
    end else if (start) begin
      pulse_q   <= 1'b1;
      pul_cnt_q <= pul_len - CNT_W'(1);
    end else if (pulse_q) begin
      if (pul_cnt_q == '0) pulse_q <= 1'b0;
      else                 pul_cnt_q <= pul_cnt_q - CNT_W'(1);
    end
  end

  assign ir_o   = pulse_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/irsir_rx_stretch.sv
module irsir_rx_stretch #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ir_ni,
  input  logic [CNT_W-1:0] bit_len_i,
  output logic             nrz_o,
  output logic             act_no
);
  logic             last_q, stretch_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;

  assign fall = last_q & ~ir_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= 1'b1;
      stretch_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      last_q <= ir_ni;
      if (fall) begin
        stretch_q <= 1'b1;
        cnt_q     <= '0;
      end else if (stretch_q) begin
        if (cnt_q == bit_len_i - CNT_W'(1)) stretch_q <= 1'b0;
        else                                cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign nrz_o  = ~stretch_q;
  assign act_no = ~stretch_q;
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int unsigned BASE_BIT_CLKS = 32,
  parameter int unsigned SHORT_CLKS    = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] rate_code_i,
  input  logic       short_pulse_i,
  input  logic       txd_i,
  output logic       ir_tx_o,
  input  logic       ir_rx_ni,
  output logic       rxd_o,
  output logic       tx_act_no,
  output logic       rx_act_no
);
  localparam int unsigned CNT_W = $clog2(BASE_BIT_CLKS * MAX_MULT + 1);

  logic [3:0]       rate_q;
  logic [CNT_W-1:0] bit_len, tri_len;
  logic             txd_s, ir_rx_s, tx_busy;

  irsir_rate_sel #(.BASE_BIT_CLKS(BASE_BIT_CLKS), .CNT_W(CNT_W)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (rate_code_i),
    .code_o   (rate_q),
    .bit_len_o(bit_len),
    .tri_len_o(tri_len)
  );

  irsir_sync2 #(.RST_VAL(1'b1)) u_sync_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(txd_i), .q_o(txd_s)
  );

  irsir_sync2 #(.RST_VAL(1'b1)) u_sync_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ir_rx_ni), .q_o(ir_rx_s)
  );

  irsir_tx_shaper #(.CNT_W(CNT_W), .SHORT_CLKS(SHORT_CLKS)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .nrz_i    (txd_s),
    .short_i  (short_pulse_i),
    .bit_len_i(bit_len),
    .tri_len_i(tri_len),
    .ir_o     (ir_tx_o),
    .busy_o   (tx_busy)
  );

  irsir_rx_stretch #(.CNT_W(CNT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ir_ni    (ir_rx_s),
    .bit_len_i(bit_len),
    .nrz_o    (rxd_o),
    .act_no   (rx_act_no)
  );

  assign tx_act_no = ~tx_busy;
endmodule

// File: rtl/irsir_codec_chk.sv
module irsir_codec_chk
  import irsir_pkg::*;
#(
  parameter int unsigned BASE_BIT_CLKS = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] rate_code_i,
  input logic       txd_i,
  input logic       ir_tx_o,
  input logic       ir_rx_ni,
  input logic       rxd_o,
  input logic       tx_act_no,
  input logic [3:0] rate_q
);
  localparam int unsigned MAX_PULSE = BASE_BIT_CLKS * 3 / 16 * MAX_MULT;
  localparam int unsigned RUN_W     = $clog2(MAX_PULSE + 2);

  logic [RUN_W-1:0] high_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        high_run_q <= '0;
    else if (!ir_tx_o)                  high_run_q <= '0;
    else if (high_run_q != {RUN_W{1'b1}}) high_run_q <= high_run_q + RUN_W'(1);
  end

  // R3
  tx_rise_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ir_tx_o) |-> !$past(txd_i, 3));

  // R6
  rx_fall_needs_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rxd_o) |-> !$past(ir_rx_ni, 3));

  // R5
  tx_pulse_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_tx_o |-> (high_run_q < RUN_W'(MAX_PULSE)));

  // R9
  invalid_code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_code_i > LAST_CODE) |=> $stable(rate_q));

  // R2
  rate_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_q <= LAST_CODE);

  // R10
  tx_ind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_tx_o |-> !tx_act_no);
endmodule

bind irsir_codec irsir_codec_chk #(.BASE_BIT_CLKS(BASE_BIT_CLKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rate_code_i(rate_code_i),
  .txd_i      (txd_i),
  .ir_tx_o    (ir_tx_o),
  .ir_rx_ni   (ir_rx_ni),
  .rxd_o      (rxd_o),
  .tx_act_no  (tx_act_no),
  .rate_q     (rate_q)
);

// File: tb/sim_irsir_codec.sv
module sim_irsir_codec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rate_code;
  logic       short_pulse, txd, ir_rx_n;
  logic       ir_tx, rxd, tx_act_n, rx_act_n;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  irsir_codec u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rate_code_i  (rate_code),
    .short_pulse_i(short_pulse),
    .txd_i        (txd),
    .ir_tx_o      (ir_tx),
    .ir_rx_ni     (ir_rx_n),
    .rxd_o        (rxd),
    .tx_act_no    (tx_act_n),
    .rx_act_no    (rx_act_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mult(input int c);
    int t[13] = '{1, 2, 3, 6, 8, 9, 12, 16, 24, 32, 48, 64, 96};
    return t[c];
  endfunction

  function automatic int bit_clks(input int c);
    return 32 * mult(c);
  endfunction

  task automatic set_rate(input int c, input bit s);
    @(negedge clk);
    rate_code   = 4'(c);
    short_pulse = s;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rate_code = 4'hF; short_pulse = 1'b1; txd = 1'b1; ir_rx_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    chk(ir_tx == 1'b0, "R1 ir_tx in reset", int'(ir_tx), 0);
    chk(rxd == 1'b1 && tx_act_n == 1'b1 && rx_act_n == 1'b1, "R1 idle outputs in reset",
        int'({rxd, tx_act_n, rx_act_n}), 7);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(ir_tx == 1'b0 && rxd == 1'b1, "R1 idle after reset", int'({ir_tx, rxd}), 1);
  endtask

  // one UART frame: start, 8 data bits LSB first, stop
  task automatic t_tx_frame(input string req, input int c, input bit s, input logic [7:0] b);
    int   l = bit_clks(c);
    int   plen = s ? 6 : 6 * mult(c);
    logic [9:0] fr = {1'b1, b, 1'b0};
    int   zeros = 0, rises = 0, high = 0, act = 0, first = -1;
    logic prev;
    set_rate(c, s);
    for (int k = 0; k < 10; k++) if (!fr[k]) zeros++;
    prev = ir_tx;
    for (int i = 0; i < 10 * l + 40; i++) begin
      @(negedge clk);
      txd = (i < 10 * l) ? fr[i / l] : 1'b1;
      if (ir_tx && !prev) begin
        rises++;
        if (first < 0) first = i;
      end
      if (ir_tx) high++;
      if (!tx_act_n) act++;
      prev = ir_tx;
    end
    // R3
    chk(rises == zeros, {req, " R3 pulse count"}, rises, zeros);
    chk(first == 3, {req, " R3 first pulse edge"}, first, 3);
    // R4 / R5
    chk(high == zeros * plen, {req, s ? " R4 pulse width" : " R5 pulse width"}, high, zeros * plen);
    // R10
    chk(act == zeros * l, {req, " R10 tx indicator"}, act, zeros * l);
  endtask

  // pulse of w cycles at 0; optional second pulse of w2 cycles at d2
  task automatic t_rx(input string req, input int l, input int w, input int d2, input int w2);
    int exp_low = (d2 > 0) ? d2 + l : l;
    int first = -1, low = 0, mism = 0;
    for (int i = 0; i < exp_low + w + 30; i++) begin
      @(negedge clk);
      ir_rx_n = !((i < w) || (d2 > 0 && i >= d2 && i < d2 + w2));
      if (!rxd) begin
        low++;
        if (first < 0) first = i;
      end
      if (rx_act_n != rxd) mism++;
    end
    // R6
    chk(first == 3, {req, " R6 stretch start"}, first, 3);
    chk(low == exp_low, {req, " stretch length"}, low, exp_low);
    // R10
    chk(mism == 0, {req, " R10 rx indicator"}, mism, 0);
  endtask

  task automatic t_tx_cases();
    t_tx_frame("9k6 short", 6, 1'b1, 8'h06);
    t_tx_frame("9k6 tri", 6, 1'b0, 8'h06);
    t_tx_frame("115k2 tri", 0, 1'b0, 8'h00);
    t_tx_frame("1k2 short", 12, 1'b1, 8'h55);
    t_tx_frame("12k8 tri", 5, 1'b0, 8'hF0);
  endtask

  task automatic t_rx_cases();
    set_rate(0, 1'b1);
    t_rx("R2 115k2", bit_clks(0), 2, 0, 0);
    set_rate(3, 1'b1);
    t_rx("R2 19k2", bit_clks(3), 6, 0, 0);
    t_rx("R7 long input", bit_clks(3), 300, 0, 0);
    t_rx("R8 retrigger", bit_clks(3), 6, 100, 6);
    set_rate(12, 1'b1);
    t_rx("R2 1k2", bit_clks(12), 6, 0, 0);
  endtask

  task automatic t_invalid();
    set_rate(0, 1'b1);
    set_rate(13, 1'b1);
    t_rx("R9 code 13 keeps 115k2", bit_clks(0), 6, 0, 0);
    set_rate(15, 1'b1);
    t_rx("R9 code 15 keeps 115k2", bit_clks(0), 6, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    // R1, R9: invalid code held through reset gives the default 384-cycle bit
    t_rx("R1 default rate", 384, 6, 0, 0);
    t_tx_cases();
    t_rx_cases();
    t_invalid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule